// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits in the fetch or decode stage of a 32-bit integer core that supports the 16-bit compressed instruction extension. Each cycle it may accept one 32-bit fetched word. If the low half is a compressed parcel, it rebuilds the equivalent 32-bit base-integer encoding. This includes unscrambling the immediate, widening any 3-bit register field to x8..x15 and choosing the implied registers (x0, x1, x2). It also flags any encoding that is reserved or not defined for a 32-bit core. A word whose two low bits are both set is already a full-length instruction and passes through unchanged.

For every accepted word, the result leaves one cycle later. The result carries the 32-bit instruction, a compressed/full-length flag, an illegal flag and the program-counter increment (2 or 4). An illegal parcel always yields an all-zero instruction, so that later stages never see half-decoded fields. Downstream decides which half of the fetched word is presented. The upper half of a compressed word is ignored.

The output stage is a two-state machine. `ST_EMPTY` holds no result and `ST_FULL` holds one. Its transitions are:
- LOAD (EMPTY to FULL): an input is accepted.
- HOLD (FULL to FULL): the result is not taken.
- REFILL (FULL to FULL): the result is taken and a new input is accepted in the same cycle.
- DRAIN (FULL to EMPTY): the result is taken and no input is accepted.

Top module: `rvc_expander`

## Requirements
- R1: A word with bits 1:0 not equal to 2'b11 is compressed: `out_compressed`=1 and `out_pc_inc`=2, and bits 31:16 are ignored. A word with bits 1:0 = 2'b11 is output unchanged with `out_compressed`=0, `out_pc_inc`=4 and `out_illegal`=0. A legal output always has bits 1:0 = 2'b11.
- R2: A 3-bit register field (bits 4:2 or bits 9:7) names register 8 plus the field value.
- R3: Quadrant 0 funct3=000 becomes ADDI rd', x2, uimm. The immediate is zero-extended, a multiple of 4 and at most 0x3FC. A zero immediate, including the all-zero parcel, is illegal.
- R4: Quadrant 0 funct3=010 and funct3=110 become LW and SW. Each uses a base register in x8..x15 and an unsigned offset that is a multiple of 4, with a maximum of 0x7C.
- R5: Quadrant 1 funct3=000 becomes ADDI rd, rd, imm, and funct3=010 becomes ADDI rd, x0, imm. In both, imm is the sign-extension of {bit12, bits 6:2}.
- R6: Quadrant 1 funct3=011 with rd=2 becomes ADDI x2, x2, imm, with imm sign-extended and a multiple of 16. With any other nonzero rd it becomes LUI, with the sign-extended 6-bit value placed in bits 17:12. A zero immediate is illegal in both forms, and rd=0 is illegal.
- R7: Quadrant 1 funct3=001 becomes JAL x1 and funct3=101 becomes JAL x0. Both use a signed 12-bit even offset.
- R8: Quadrant 1 funct3=110 and funct3=111 become BEQ and BNE of rs1' against x0, with a signed 9-bit even offset.
- R9: Right shifts (quadrant 1 funct3=100, bits 11:10 = 00 or 01) and left shift (quadrant 2 funct3=000) become shift-immediate instructions. They are illegal when bit 12 is set. Bits 11:10 = 10 become ANDI rd', rd', imm with a sign-extended 6-bit imm.
- R10: Quadrant 1 funct3=100, bits 11:10 = 11 and bit 12 = 0 select SUB, XOR, OR or AND by bits 6:5 = 00, 01, 10, 11, with rd' = rs1'. With bit 12 = 1 the encoding is illegal.
- R11: Quadrant 2 expands the stack-pointer forms LWSP and SWSP, with rd=0 illegal for LWSP. It also expands JR, MV, EBREAK, JALR and ADD, with JR of x0 illegal.
- R12: Floating-point, 64/128-bit-only and reserved encodings are flagged illegal, and every illegal parcel outputs 32'h0.
- R13: A result appears one cycle after its input is accepted. The result stays stable while `out_valid` is high and `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R14: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched word is present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 32 | Fetched word; low half is a compressed parcel when bits 1:0 != 11 |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_instr | output | 32 | Expanded or passed-through instruction, zero if illegal |
| out_compressed | output | 1 | Source was a 16-bit parcel |
| out_illegal | output | 1 | Source encoding is illegal on this core |
| out_pc_inc | output | 3 | Program-counter increment, 2 or 4 |

## Verification
The assertions on the output register assume the consumer follows the handshake: `out_ready` may drop at any time, and `in_word` matters only in cycles where `in_valid` and `in_ready` are both high. The bench drives inputs only at the falling edge and randomises both `in_valid` and `out_ready`. This exercises stalls, back-to-back refills and drains while keeping every transfer legal. A directed list covers each quadrant's reserved and boundary immediates. It is followed by random words in which roughly three quarters are compressed, and their upper halves are filled with garbage to confirm that those bits have no effect.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
    localparam int ILEN   = 32;
    localparam int CLEN   = 16;
    localparam int INC_W  = 3;
    localparam int REG_W  = 5;

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [ILEN-1:0] INSN_EBREAK = 32'h0010_0073;

    localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
    localparam logic [REG_W-1:0] REG_LINK = 5'd1;
    localparam logic [REG_W-1:0] REG_SP   = 5'd2;

    typedef struct packed {
        logic [ILEN-1:0]  instr;
        logic             illegal;
        logic             compressed;
        logic [INC_W-1:0] pc_inc;
    } xres_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_t;

    function automatic logic [ILEN-1:0] fmt_i(logic [11:0] imm, logic [4:0] rs1,
                                              logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [ILEN-1:0] fmt_s(logic [11:0] imm, logic [4:0] rs2,
                                              logic [4:0] rs1, logic [2:0] f3, logic [6:0] op);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
    endfunction

    function automatic logic [ILEN-1:0] fmt_b(logic [12:0] imm, logic [4:0] rs2,
                                              logic [4:0] rs1, logic [2:0] f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
    endfunction

    function automatic logic [ILEN-1:0] fmt_j(logic [20:0] imm, logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
    endfunction

    function automatic logic [ILEN-1:0] fmt_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                              logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction
endpackage

// File: rtl/rvc_decode.sv
module rvc_decode
    import rvc_pkg::*;
(
    input  logic [ILEN-1:0] word,
    output xres_t           res
);
    logic [CLEN-1:0]  c;
    logic [REG_W-1:0] rd_full, rs2_full, rd_cmp, rs1_cmp;
    logic [11:0]      imm_ci;
    logic [9:0]       imm_4spn;
    logic [6:0]       imm_lsw;
    logic [11:0]      imm_jmp;
    logic [9:0]       imm_16sp;
    logic [8:0]       imm_br;
    logic [7:0]       imm_lwsp, imm_swsp;
    logic             ci_zero;

    assign c        = word[CLEN-1:0];
    assign rd_full  = c[11:7];
    assign rs2_full = c[6:2];
    assign rd_cmp   = {2'b01, c[4:2]};
    assign rs1_cmp  = {2'b01, c[9:7]};
    assign ci_zero  = ({c[12], c[6:2]} == 6'd0);

    assign imm_ci   = {{6{c[12]}}, c[12], c[6:2]};
    assign imm_4spn = {c[10:7], c[12:11], c[5], c[6], 2'b00};
    assign imm_lsw  = {c[5], c[12:10], c[6], 2'b00};
    assign imm_jmp  = {c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
    assign imm_16sp = {c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
    assign imm_br   = {c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
    assign imm_lwsp = {c[3:2], c[12], c[6:4], 2'b00};
    assign imm_swsp = {c[8:7], c[12:9], 2'b00};

    always_comb begin
        logic [ILEN-1:0] ins;
        logic            bad;
        ins = '0;
        bad = 1'b0;
        res.compressed = (c[1:0] != 2'b11);
        res.pc_inc     = res.compressed ? INC_W'(2) : INC_W'(4);
        if (!res.compressed) begin
            ins = word;
        end else begin
            case ({c[1:0], c[15:13]})
                // quadrant 0
                5'b00_000: begin
                    bad = (imm_4spn == 10'd0);
                    ins = fmt_i({2'b00, imm_4spn}, REG_SP, 3'b000, rd_cmp, OPC_OPIMM);
                end
                5'b00_010: ins = fmt_i({5'b0, imm_lsw}, rs1_cmp, 3'b010, rd_cmp, OPC_LOAD);
                5'b00_110: ins = fmt_s({5'b0, imm_lsw}, rd_cmp, rs1_cmp, 3'b010, OPC_STORE);
                // quadrant 1
                5'b01_000: ins = fmt_i(imm_ci, rd_full, 3'b000, rd_full, OPC_OPIMM);
                5'b01_001: ins = fmt_j({{9{c[12]}}, imm_jmp}, REG_LINK);
                5'b01_010: ins = fmt_i(imm_ci, REG_ZERO, 3'b000, rd_full, OPC_OPIMM);
                5'b01_011: begin
                    if (rd_full == REG_SP) begin
                        bad = ci_zero;
                        ins = fmt_i({{2{c[12]}}, imm_16sp}, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
                    end else begin
                        bad = ci_zero || (rd_full == REG_ZERO);
                        ins = {{14{c[12]}}, c[12], c[6:2], rd_full, OPC_LUI};
                    end
                end
                5'b01_100: begin
                    case (c[11:10])
                        2'b00, 2'b01: begin
                            bad = c[12];
                            ins = fmt_r({1'b0, c[10], 5'b0}, c[6:2], rs1_cmp, 3'b101,
                                        rs1_cmp, OPC_OPIMM);
                        end
                        2'b10: ins = fmt_i(imm_ci, rs1_cmp, 3'b111, rs1_cmp, OPC_OPIMM);
                        default: begin
                            bad = c[12];
                            case (c[6:5])
                                2'b00:   ins = fmt_r(7'b0100000, rd_cmp, rs1_cmp, 3'b000, rs1_cmp, OPC_OP);
                                2'b01:   ins = fmt_r(7'b0000000, rd_cmp, rs1_cmp, 3'b100, rs1_cmp, OPC_OP);
                                2'b10:   ins = fmt_r(7'b0000000, rd_cmp, rs1_cmp, 3'b110, rs1_cmp, OPC_OP);
                                default: ins = fmt_r(7'b0000000, rd_cmp, rs1_cmp, 3'b111, rs1_cmp, OPC_OP);
                            endcase
                        end
                    endcase
                end
                5'b01_101: ins = fmt_j({{9{c[12]}}, imm_jmp}, REG_ZERO);
                5'b01_110,
                5'b01_111: ins = fmt_b({{4{c[12]}}, imm_br}, REG_ZERO, rs1_cmp, {2'b00, c[13]});
                // quadrant 2
                5'b10_000: begin
                    bad = c[12];
                    ins = fmt_r(7'b0, c[6:2], rd_full, 3'b001, rd_full, OPC_OPIMM);
                end
                5'b10_010: begin
                    bad = (rd_full == REG_ZERO);
                    ins = fmt_i({4'b0, imm_lwsp}, REG_SP, 3'b010, rd_full, OPC_LOAD);
                end
                5'b10_100: begin
                    if (!c[12]) begin
                        if (rs2_full == REG_ZERO) begin
                            bad = (rd_full == REG_ZERO);
                            ins = fmt_i(12'd0, rd_full, 3'b000, REG_ZERO, OPC_JALR);
                        end else begin
                            ins = fmt_r(7'b0, rs2_full, REG_ZERO, 3'b000, rd_full, OPC_OP);
                        end
                    end else if (rs2_full == REG_ZERO && rd_full == REG_ZERO) begin
                        ins = INSN_EBREAK;
                    end else if (rs2_full == REG_ZERO) begin
                        ins = fmt_i(12'd0, rd_full, 3'b000, REG_LINK, OPC_JALR);
                    end else begin
                        ins = fmt_r(7'b0, rs2_full, rd_full, 3'b000, rd_full, OPC_OP);
                    end
                end
                5'b10_110: ins = fmt_s({4'b0, imm_swsp}, rs2_full, REG_SP, 3'b010, OPC_STORE);
                default:   bad = 1'b1;
            endcase
        end
        res.illegal = bad;
        res.instr   = bad ? '0 : ins;
    end
endmodule

// File: rtl/rvc_out_stage.sv
module rvc_out_stage
    import rvc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  xres_t in_res,
    output logic  out_valid,
    input  logic  out_ready,
    output xres_t out_res
);
    stage_st_t state, state_nx;
    xres_t     held;
    logic      take;

    assign take = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (in_valid) state_nx = ST_FULL;            // LOAD
            ST_FULL:  if (out_ready && !in_valid) state_nx = ST_EMPTY; // DRAIN; else HOLD/REFILL
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (take) held <= in_res;
    end

    always_comb begin
        unique case (state)
            ST_EMPTY: begin out_valid = 1'b0; in_ready = 1'b1; end
            ST_FULL:  begin out_valid = 1'b1; in_ready = out_ready; end
        endcase
        out_res = held;
    end

    assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));
    assert_ready_when_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    assert_illegal_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_res.illegal) |-> (out_res.instr == '0));
    assert_legal_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_res.illegal) |-> (out_res.instr[1:0] == 2'b11));
    assert_full_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_res.compressed) |-> (!out_res.illegal && out_res.pc_inc == 3'd4));
    assert_short_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_res.compressed) |-> (out_res.pc_inc == 3'd2));
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
    import rvc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ILEN-1:0]  in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ILEN-1:0]  out_instr,
    output logic             out_compressed,
    output logic             out_illegal,
    output logic [INC_W-1:0] out_pc_inc
);
    xres_t dec_res, reg_res;

    rvc_decode u_decode (
        .word (in_word),
        .res  (dec_res)
    );

    rvc_out_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_res    (dec_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (reg_res)
    );

    assign out_instr      = reg_res.instr;
    assign out_compressed = reg_res.compressed;
    assign out_illegal    = reg_res.illegal;
    assign out_pc_inc     = reg_res.pc_inc;
endmodule

// File: tb/tb_rvc_expander.sv
module tb_rvc_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_instr;
    logic        out_compressed;
    logic        out_illegal;
    logic [2:0]  out_pc_inc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam int N_DIR  = 62;
    localparam int N_RAND = 3000;

    always #4 clk = ~clk;   // 125 MHz

    rvc_expander dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_compressed(out_compressed),
        .out_illegal(out_illegal), .out_pc_inc(out_pc_inc)
    );

    // ---------------- behavioural reference ----------------
    function automatic int fb(int v, int hi, int lo);
        return (v >> lo) & ((1 << (hi - lo + 1)) - 1);
    endfunction
    function automatic int sx(int v, int bits);
        return (v ^ (1 << (bits - 1))) - (1 << (bits - 1));
    endfunction
    function automatic logic [31:0] mk_i(int imm, int rs1, int f3, int rd, int op);
        return ((imm & 'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
    endfunction
    function automatic logic [31:0] mk_s(int imm, int rs2, int rs1, int f3, int op);
        return (fb(imm, 11, 5) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (fb(imm, 4, 0) << 7) | op;
    endfunction
    function automatic logic [31:0] mk_b(int imm, int rs1, int f3);
        return (fb(imm, 12, 12) << 31) | (fb(imm, 10, 5) << 25) | (rs1 << 15) | (f3 << 12)
             | (fb(imm, 4, 1) << 8) | (fb(imm, 11, 11) << 7) | 'h63;
    endfunction
    function automatic logic [31:0] mk_j(int imm, int rd);
        return (fb(imm, 20, 20) << 31) | (fb(imm, 10, 1) << 21) | (fb(imm, 11, 11) << 20)
             | (fb(imm, 19, 12) << 12) | (rd << 7) | 'h6f;
    endfunction
    function automatic logic [31:0] mk_r(int f7, int rs2, int rs1, int f3, int rd, int op);
        return (f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
    endfunction

    task automatic model(input logic [31:0] w, output logic [31:0] ins, output logic ill,
                         output logic comp, output logic [2:0] inc, output string tag);
        int c, q, f3, rd, rs2, rdp, rs1p, imm, ci, jo, sub;
        ins = '0; ill = 1'b0;
        if (w[1:0] == 2'b11) begin
            ins = w; comp = 1'b0; inc = 3'd4; tag = "R1"; return;
        end
        comp = 1'b1; inc = 3'd2;
        c = int'(w[15:0]);
        q = fb(c, 1, 0); f3 = fb(c, 15, 13);
        rd = fb(c, 11, 7); rs2 = fb(c, 6, 2);
        rdp = 8 + fb(c, 4, 2); rs1p = 8 + fb(c, 9, 7);
        ci = sx((fb(c, 12, 12) << 5) | fb(c, 6, 2), 6);
        jo = sx((fb(c,12,12) << 11) | (fb(c,11,11) << 4) | (fb(c,10,9) << 8) | (fb(c,8,8) << 10)
               | (fb(c,7,7) << 6) | (fb(c,6,6) << 7) | (fb(c,5,3) << 1) | (fb(c,2,2) << 5), 12);
        tag = "R12"; ill = 1'b1;
        if (q == 0) begin
            if (f3 == 0) begin
                tag = "R3";
                imm = (fb(c,12,11) << 4) | (fb(c,10,7) << 6) | (fb(c,6,6) << 2) | (fb(c,5,5) << 3);
                ill = (imm == 0);
                ins = mk_i(imm, 2, 0, rdp, 'h13);
            end else if (f3 == 2 || f3 == 6) begin
                tag = "R4 R2"; ill = 1'b0;
                imm = (fb(c,12,10) << 3) | (fb(c,6,6) << 2) | (fb(c,5,5) << 6);
                ins = (f3 == 2) ? mk_i(imm, rs1p, 2, rdp, 'h03) : mk_s(imm, rdp, rs1p, 2, 'h23);
            end
        end else if (q == 1) begin
            ill = 1'b0;
            case (f3)
                0: begin tag = "R5"; ins = mk_i(ci, rd, 0, rd, 'h13); end
                2: begin tag = "R5"; ins = mk_i(ci, 0, 0, rd, 'h13); end
                1: begin tag = "R7"; ins = mk_j(jo, 1); end
                5: begin tag = "R7"; ins = mk_j(jo, 0); end
                3: begin
                    tag = "R6";
                    if (rd == 2) begin
                        imm = sx((fb(c,12,12) << 9) | (fb(c,6,6) << 4) | (fb(c,5,5) << 6)
                                 | (fb(c,4,3) << 7) | (fb(c,2,2) << 5), 10);
                        ill = (imm == 0);
                        ins = mk_i(imm, 2, 0, 2, 'h13);
                    end else begin
                        ill = (ci == 0) || (rd == 0);
                        ins = ((ci & 'hfffff) << 12) | (rd << 7) | 'h37;
                    end
                end
                4: begin
                    sub = fb(c, 11, 10);
                    if (sub <= 1) begin
                        tag = "R9"; ill = fb(c,12,12) != 0;
                        ins = mk_r(sub ? 'h20 : 0, rs2, rs1p, 5, rs1p, 'h13);
                    end else if (sub == 2) begin
                        tag = "R9"; ins = mk_i(ci, rs1p, 7, rs1p, 'h13);
                    end else begin
                        tag = "R10 R2"; ill = fb(c,12,12) != 0;
                        case (fb(c, 6, 5))
                            0: ins = mk_r('h20, rdp, rs1p, 0, rs1p, 'h33);
                            1: ins = mk_r(0, rdp, rs1p, 4, rs1p, 'h33);
                            2: ins = mk_r(0, rdp, rs1p, 6, rs1p, 'h33);
                            default: ins = mk_r(0, rdp, rs1p, 7, rs1p, 'h33);
                        endcase
                    end
                end
                default: begin
                    tag = "R8";
                    imm = sx((fb(c,12,12) << 8) | (fb(c,11,10) << 3) | (fb(c,6,5) << 6)
                             | (fb(c,4,3) << 1) | (fb(c,2,2) << 5), 9);
                    ins = mk_b(imm, rs1p, f3 - 6);
                end
            endcase
        end else begin
            if (f3 == 0) begin
                tag = "R9"; ill = fb(c,12,12) != 0;
                ins = mk_r(0, rs2, rd, 1, rd, 'h13);
            end else if (f3 == 2) begin
                tag = "R11"; ill = (rd == 0);
                imm = (fb(c,12,12) << 5) | (fb(c,6,4) << 2) | (fb(c,3,2) << 6);
                ins = mk_i(imm, 2, 2, rd, 'h03);
            end else if (f3 == 6) begin
                tag = "R11"; ill = 1'b0;
                imm = (fb(c,12,9) << 2) | (fb(c,8,7) << 6);
                ins = mk_s(imm, rs2, 2, 2, 'h23);
            end else if (f3 == 4) begin
                tag = "R11"; ill = 1'b0;
                if (fb(c,12,12) == 0) begin
                    if (rs2 == 0) begin ill = (rd == 0); ins = mk_i(0, rd, 0, 0, 'h67); end
                    else ins = mk_r(0, rs2, 0, 0, rd, 'h33);
                end else begin
                    if (rs2 == 0 && rd == 0) ins = 32'h0010_0073;
                    else if (rs2 == 0) ins = mk_i(0, rd, 0, 1, 'h67);
                    else ins = mk_r(0, rs2, rd, 0, rd, 'h33);
                end
            end
        end
        if (ill) ins = '0;
    endtask

    function automatic logic [31:0] directed(int i);
        case (i)
            0:  return 32'h0000_0000;  1:  return 32'h0000_1FE8;  2:  return 32'h0000_0040;
            3:  return 32'h0000_5FF4;  4:  return 32'h0000_DFF4;  5:  return 32'h0000_2000;
            6:  return 32'h0000_8000;  7:  return 32'h0000_6000;  8:  return 32'h0000_A000;
            9:  return 32'h0000_E000;  10: return 32'h0000_0001;  11: return 32'h0000_12FD;
            12: return 32'h0000_3FFD;  13: return 32'h0000_2005;  14: return 32'h0000_B7FD;
            15: return 32'h0000_5505;  16: return 32'h0000_6101;  17: return 32'h0000_717D;
            18: return 32'h0000_6141;  19: return 32'h0000_6281;  20: return 32'h0000_6285;
            21: return 32'h0000_7285;  22: return 32'h0000_6005;  23: return 32'h0000_8005;
            24: return 32'h0000_9005;  25: return 32'h0000_8405;  26: return 32'h0000_9405;
            27: return 32'h0000_8805;  28: return 32'h0000_9885;  29: return 32'h0000_8C09;
            30: return 32'h0000_8C29;  31: return 32'h0000_8C49;  32: return 32'h0000_8C69;
            33: return 32'h0000_9C09;  34: return 32'h0000_9C29;  35: return 32'h0000_9C49;
            36: return 32'h0000_C401;  37: return 32'h0000_DFFD;  38: return 32'h0000_E001;
            39: return 32'h0000_FC7D;  40: return 32'h0000_0296;  41: return 32'h0000_1296;
            42: return 32'h0000_4082;  43: return 32'h0000_4002;  44: return 32'h0000_5FFE;
            45: return 32'h0000_8082;  46: return 32'h0000_8002;  47: return 32'h0000_8096;
            48: return 32'h0000_9002;  49: return 32'h0000_9082;  50: return 32'h0000_9096;
            51: return 32'h0000_C006;  52: return 32'h0000_DFFE;  53: return 32'h0000_2002;
            54: return 32'h0000_6002;  55: return 32'h0000_A002;  56: return 32'h0000_E002;
            57: return 32'h0050_0093;  58: return 32'hFFFF_FFFF;  59: return 32'hABCD_0001;
            60: return 32'h1234_8C69;  61: return 32'hFFFF_0000;
            default: return 32'h0000_0001;
        endcase
    endfunction

    // ---------------- stimulus and scoreboard ----------------
    logic [36:0] exp_q[$];
    string       tag_q[$];

    initial begin
        int idx;
        logic [31:0] e_ins; logic e_ill, e_comp; logic [2:0] e_inc; string e_tag;
        logic [36:0] got, want, snap;
        logic hold_prev;
        idx = 0; hold_prev = 1'b0; snap = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R14 reset: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end
        while (!done) begin
            @(negedge clk);
            if (idx < N_DIR + N_RAND) begin
                in_valid = ($urandom_range(0, 9) < 8);
                in_word  = (idx < N_DIR) ? directed(idx) : $urandom();
            end else begin
                in_valid = 1'b0;
            end
            out_ready = ($urandom_range(0, 9) < 7);
            #1;
            checks++;
            if (in_ready !== (!out_valid || out_ready)) begin
                errors++;
                $display("FAIL R13 in_ready=%0b expected %0b", in_ready, !out_valid || out_ready);
            end
            got = {out_instr, out_illegal, out_compressed, out_pc_inc};
            if (hold_prev) begin
                checks++;
                if (out_valid !== 1'b1 || got !== snap) begin
                    errors++;
                    $display("FAIL R13 held result changed: got %h expected %h", got, snap);
                end
            end
            hold_prev = out_valid && !out_ready;
            snap = got;
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R13 unexpected result %h expected none", got);
                end else begin
                    want = exp_q.pop_front();
                    e_tag = tag_q.pop_front();
                    if (got !== want) begin
                        errors++;
                        $display("FAIL %s instr=%h ill=%0b comp=%0b inc=%0d expected instr=%h ill=%0b comp=%0b inc=%0d",
                                 e_tag, got[36:5], got[4], got[3], got[2:0],
                                 want[36:5], want[4], want[3], want[2:0]);
                    end
                end
            end
            if (in_valid && in_ready) begin
                model(in_word, e_ins, e_ill, e_comp, e_inc, e_tag);
                exp_q.push_back({e_ins, e_ill, e_comp, e_inc});
                tag_q.push_back(e_tag);
                idx++;
            end
            if (idx >= N_DIR + N_RAND && exp_q.size() == 0 && !out_valid) done = 1;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R13 watchdog expired: pending=%0d expected 0", exp_q.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule